// File: doc/BRIEF.md
# Exception control register unit

This unit keeps the system-control state a processor needs for interrupts and exceptions. It holds four registers: a status word, a cause word, a saved exception program counter and a captured faulting address. Software reaches them through a move-to write port and a combinational move-from read port. Both ports select a register by number.

When the pipeline raises an exception request, the unit saves the faulting PC and records the cause code. It pushes the three-level mode and interrupt-enable stack in the status word. In the same cycle it drives a redirect to the fixed handler address. A return-from-exception strobe pops that stack. The unit also merges six hardware interrupt lines and two software-set pending bits with the mask bits and the current enable bit into one interrupt request for the pipeline.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset, every register reads as zero, `irq_req` is 0, and the unit is in kernel mode with interrupts disabled.
- R2: Register select 12 is status, 13 is cause, 14 is the exception PC and 8 is the bad address. Any other select reads 0. Status bits 15..8 and 5..0 are writable and its other bits read 0. Only cause bits 9..8 are writable. The exception PC is fully writable. Writes to select 8 are ignored.
- R3: While `exc_req` is high, `redirect` is high and `redirect_pc` is 0x80000080. On the edge, the exception PC register takes `exc_pc`.
- R4: An exception shifts status bits 5..0 left by two and clears bits 1..0. Bit 0 is the current interrupt enable (1 = allowed) and bit 1 is the current mode (1 = user, 0 = kernel).
- R5: A return-from-exception without an exception in the same cycle moves status bits 5..2 into bits 3..0. Bits 5..4 keep their value.
- R6: Cause bits 15..10 show `hw_irq` as sampled at the previous clock edge. Cause bits 9..8 are set by software. Bits 7 and 1..0 read 0.
- R7: `irq_req` is high exactly when status bit 0 is 1 and the AND of cause bits 15..8 with status bits 15..8 is nonzero.
- R8: An exception taken while `irq_req` is high stores exception code 0 in cause bits 6..2. Otherwise the stored code is `exc_code`.
- R9: The bad-address register loads `exc_badaddr` only on an exception that stores code 4 or 5. Every other exception leaves it unchanged.
- R10: An exception discards any move-to write and any return-from-exception in the same cycle. A return-from-exception discards a move-to write to status in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mt_en | input | 1 | Move-to write strobe |
| mt_sel | input | 5 | Move-to register number |
| mt_data | input | 32 | Move-to write data |
| mf_sel | input | 5 | Move-from register number |
| mf_data | output | 32 | Move-from read data |
| exc_req | input | 1 | Exception request |
| exc_code | input | 5 | Exception code from the pipeline |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_badaddr | input | 32 | Faulting address for address errors |
| rfe | input | 1 | Return-from-exception strobe |
| hw_irq | input | 6 | Hardware interrupt lines |
| irq_req | output | 1 | Interrupt request to the pipeline |
| redirect | output | 1 | Next-PC override |
| redirect_pc | output | 32 | Handler vector |

## Verification
Three things can land on the same edge. An exception can meet a move-to write to status or cause. It can also meet a return-from-exception, and a return-from-exception can meet a status write. Directed cycles raise these pairs together, and a long random phase makes them collide at will. The behavioural model applies the priority order and compares every read and the interrupt request on each cycle. It also checks, during an exception, whether an interrupt request was pending, which decides if code 0 is stored.

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0080,
  parameter logic [4:0] SEL_BAD = 5'd8,
  parameter logic [4:0] SEL_STAT = 5'd12,
  parameter logic [4:0] SEL_CAUSE = 5'd13,
  parameter logic [4:0] SEL_EPC = 5'd14,
  parameter logic [4:0] CODE_ADDR_LD = 5'd4,
  parameter logic [4:0] CODE_ADDR_ST = 5'd5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mt_en,
  input  logic [4:0]      mt_sel,
  input  logic [XLEN-1:0] mt_data,
  input  logic [4:0]      mf_sel,
  output logic [XLEN-1:0] mf_data,
  input  logic            exc_req,
  input  logic [4:0]      exc_code,
  input  logic [XLEN-1:0] exc_pc,
  input  logic [XLEN-1:0] exc_badaddr,
  input  logic            rfe,
  input  logic [5:0]      hw_irq,
  output logic            irq_req,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);
  logic [5:0]      ku_ie_q;
  logic [7:0]      im_q;
  logic [1:0]      ip_sw_q;
  logic [5:0]      ip_hw_q;
  logic [4:0]      code_q;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] bad_q;

  logic [4:0] code_taken;
  logic       addr_err;

  assign irq_req     = ku_ie_q[0] & |({ip_hw_q, ip_sw_q} & im_q);
  assign code_taken  = irq_req ? 5'd0 : exc_code;
  assign addr_err    = (code_taken == CODE_ADDR_LD) || (code_taken == CODE_ADDR_ST);
  assign redirect    = exc_req;
  assign redirect_pc = VECTOR;

  always_comb begin
    mf_data = '0;
    case (mf_sel)
      SEL_STAT:  mf_data[15:0] = {im_q, 2'b00, ku_ie_q};
      SEL_CAUSE: mf_data[15:0] = {ip_hw_q, ip_sw_q, 1'b0, code_q, 2'b00};
      SEL_EPC:   mf_data = epc_q;
      SEL_BAD:   mf_data = bad_q;
      default:   mf_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ku_ie_q <= '0;
      im_q    <= '0;
      ip_sw_q <= '0;
      ip_hw_q <= '0;
      code_q  <= '0;
      epc_q   <= '0;
      bad_q   <= '0;
    end else begin
      ip_hw_q <= hw_irq;
      if (exc_req) begin
        ku_ie_q <= {ku_ie_q[3:0], 2'b00};
        code_q  <= code_taken;
        epc_q   <= exc_pc;
        if (addr_err) bad_q <= exc_badaddr;
      end else begin
        if (rfe) begin
          ku_ie_q <= {ku_ie_q[5:4], ku_ie_q[5:2]};
        end else if (mt_en && mt_sel == SEL_STAT) begin
          ku_ie_q <= mt_data[5:0];
          im_q    <= mt_data[15:8];
        end
        if (mt_en && mt_sel == SEL_STAT && rfe) im_q <= im_q;
        if (mt_en && mt_sel == SEL_CAUSE) ip_sw_q <= mt_data[9:8];
        if (mt_en && mt_sel == SEL_EPC) epc_q <= mt_data;
      end
    end
  end
endmodule

module exc_ctrl_regs_chk #(
  parameter int XLEN = 32,
  parameter logic [4:0] SEL_STAT = 5'd12,
  parameter logic [4:0] CODE_ADDR_LD = 5'd4,
  parameter logic [4:0] CODE_ADDR_ST = 5'd5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic            rfe,
  input logic [4:0]      exc_code,
  input logic [XLEN-1:0] exc_pc,
  input logic            mt_en,
  input logic [4:0]      mt_sel,
  input logic [5:0]      stack,
  input logic [XLEN-1:0] epc,
  input logic [XLEN-1:0] bad,
  input logic            irq_req,
  input logic            redirect
);
  AST_EPC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> epc == $past(exc_pc)); // R3
  AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> redirect); // R3
  AST_EXC_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> stack == {$past(stack[3:0]), 2'b00}); // R4
  AST_RFE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !exc_req) |=> stack == {$past(stack[5:4]), $past(stack[5:2])}); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !stack[0] |-> !irq_req); // R7
  AST_BAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_code != CODE_ADDR_LD && exc_code != CODE_ADDR_ST) |=> $stable(bad)); // R9
  AST_EXC_OVER_MT: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && mt_en && mt_sel == SEL_STAT) |=> stack[1:0] == 2'b00); // R10
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk #(.XLEN(XLEN), .SEL_STAT(SEL_STAT),
  .CODE_ADDR_LD(CODE_ADDR_LD), .CODE_ADDR_ST(CODE_ADDR_ST)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .rfe(rfe), .exc_code(exc_code),
  .exc_pc(exc_pc), .mt_en(mt_en), .mt_sel(mt_sel), .stack(ku_ie_q),
  .epc(epc_q), .bad(bad_q), .irq_req(irq_req), .redirect(redirect)
);

// File: tb/exc_ctrl_regs_bench.sv
module exc_ctrl_regs_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mt_en = 1'b0;
  logic [4:0]  mt_sel = '0;
  logic [31:0] mt_data = '0;
  logic [4:0]  mf_sel = '0;
  logic [31:0] mf_data;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic [31:0] exc_badaddr = '0;
  logic        rfe = 1'b0;
  logic [5:0]  hw_irq = '0;
  logic        irq_req;
  logic        redirect;
  logic [31:0] redirect_pc;

  int total = 0;
  int bad = 0;

  logic [5:0]  m_stk;
  logic [7:0]  m_im;
  logic [1:0]  m_sw;
  logic [5:0]  m_hw;
  logic [4:0]  m_code;
  logic [31:0] m_epc;
  logic [31:0] m_bad;

  exc_ctrl_regs u_exc_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .mt_sel(mt_sel), .mt_data(mt_data),
    .mf_sel(mf_sel), .mf_data(mf_data), .exc_req(exc_req), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_badaddr(exc_badaddr), .rfe(rfe), .hw_irq(hw_irq),
    .irq_req(irq_req), .redirect(redirect), .redirect_pc(redirect_pc)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic m_irq();
    return m_stk[0] && (({m_hw, m_sw} & m_im) != 8'h00);
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] s);
    case (s)
      5'd12: return {16'h0, m_im, 2'b00, m_stk};
      5'd13: return {16'h0, m_hw, m_sw, 1'b0, m_code, 2'b00};
      5'd14: return m_epc;
      5'd8:  return m_bad;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_stk = '0; m_im = '0; m_sw = '0; m_hw = '0; m_code = '0; m_epc = '0; m_bad = '0;
  endtask

  task automatic model_edge();
    logic irq_now;
    logic [4:0] c;
    irq_now = m_irq();
    if (!rst_n) begin
      model_reset();
      return;
    end
    if (exc_req) begin
      c = irq_now ? 5'd0 : exc_code;
      m_code = c;
      m_epc = exc_pc;
      m_stk = {m_stk[3:0], 2'b00};
      if (c == 5'd4 || c == 5'd5) m_bad = exc_badaddr;
    end else begin
      if (rfe) m_stk = {m_stk[5:4], m_stk[5:2]};
      else if (mt_en && mt_sel == 5'd12) begin
        m_stk = mt_data[5:0];
        m_im = mt_data[15:8];
      end
      if (mt_en && mt_sel == 5'd13) m_sw = mt_data[9:8];
      if (mt_en && mt_sel == 5'd14) m_epc = mt_data;
    end
    m_hw = hw_irq;
  endtask

  // one cycle: compare outputs mid-low-phase, then advance both design and model
  task automatic step(input string req);
    #(PERIOD/4);
    if (rst_n) begin
      check({req, " read"}, mf_data, m_read(mf_sel));
      check({"R7 irq ", req}, {31'h0, irq_req}, {31'h0, m_irq()});
      check({"R3 redirect ", req}, {31'h0, redirect}, {31'h0, exc_req});
      if (exc_req) check("R3 vector", redirect_pc, 32'h8000_0080);
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    mt_en = 0; exc_req = 0; rfe = 0;
  endtask

  task automatic read_all(input string req);
    idle();
    foreach (sels[i]) begin
      mf_sel = sels[i];
      step(req);
    end
  endtask
  logic [4:0] sels [5] = '{5'd8, 5'd12, 5'd13, 5'd14, 5'd3};

  task automatic mt(input logic [4:0] s, input logic [31:0] d, input string req);
    idle(); mt_en = 1; mt_sel = s; mt_data = d; mf_sel = s;
    step(req);
    idle();
  endtask

  task automatic exc(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] ba, input string req);
    idle(); exc_req = 1; exc_code = c; exc_pc = pc; exc_badaddr = ba;
    step(req);
    idle();
  endtask

  initial begin
    #(PERIOD*200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    repeat (3) step("reset");
    rst_n = 1;
    read_all("R1 reset value");

    // R2 writes and masked read-back
    mt(5'd12, 32'hFFFF_FF3C, "R2 status write");
    mf_sel = 5'd12; step("R2 status readback");
    mt(5'd13, 32'hFFFF_FFFF, "R2 cause write");
    mf_sel = 5'd13; step("R6 cause sw bits");
    mt(5'd14, 32'h1234_5678, "R2 epc write");
    mt(5'd8, 32'hDEAD_BEEF, "R2 bad ignored");
    mf_sel = 5'd8; step("R2 bad unchanged");
    mt(5'd13, 32'h0, "R2 cause clear");

    // R6 hardware lines, R7 masking
    mt(5'd12, 32'h0000_0401, "R7 enable hw0");
    hw_irq = 6'b000010; mf_sel = 5'd13; step("R6 hw sample");
    step("R7 masked off");
    hw_irq = 6'b000001; step("R6 hw sample2");
    step("R7 raised");
    mt(5'd12, 32'h0000_0400, "R7 ie off");
    step("R7 ie low");
    hw_irq = 0;

    // R8 interrupt pending makes stored code zero
    mt(5'd12, 32'h0000_0105, "R8 enable sw0");
    mt(5'd13, 32'h0000_0100, "R8 set sw0");
    mf_sel = 5'd13; step("R7 sw irq");
    exc(5'd12, 32'h0040_0010, 32'h0, "R8 irq code zero");
    mf_sel = 5'd13; step("R8 code read");
    mf_sel = 5'd12; step("R4 push read");
    mf_sel = 5'd14; step("R3 epc read");
    rfe = 1; mf_sel = 5'd12; step("R5 pop"); idle();
    mt(5'd13, 32'h0, "R8 clear sw");

    // R9 bad address capture
    mt(5'd12, 32'h0000_FF00, "R9 ie off");
    exc(5'd4, 32'h0040_0100, 32'hA000_0001, "R9 load addr err");
    mf_sel = 5'd8; step("R9 bad loaded");
    exc(5'd5, 32'h0040_0104, 32'hB000_0002, "R9 store addr err");
    mf_sel = 5'd8; step("R9 bad loaded2");
    exc(5'd8, 32'h0040_0108, 32'hC000_0003, "R9 other code");
    mf_sel = 5'd8; step("R9 bad kept");
    mf_sel = 5'd13; step("R8 code 8");

    // nested push / pop
    mt(5'd12, 32'h0000_0003, "R4 user ie");
    exc(5'd10, 32'h100, 32'h0, "R4 nest1");
    exc(5'd11, 32'h200, 32'h0, "R4 nest2");
    mf_sel = 5'd12; step("R4 depth");
    rfe = 1; step("R5 pop1");
    rfe = 1; step("R5 pop2");
    idle(); step("R5 after pops");

    // R10 collisions
    mt(5'd12, 32'h0000_0015, "R10 setup");
    exc_req = 1; exc_code = 5'd9; exc_pc = 32'h300; mt_en = 1; mt_sel = 5'd12; mt_data = 32'h0000_FF3F;
    mf_sel = 5'd12; step("R10 exc over mt");
    idle(); step("R10 status after");
    exc_req = 1; exc_code = 5'd9; exc_pc = 32'h304; mt_en = 1; mt_sel = 5'd14; mt_data = 32'h5555_0000;
    mf_sel = 5'd14; step("R10 exc over epc write");
    idle(); step("R10 epc after");
    exc_req = 1; rfe = 1; exc_pc = 32'h308; mf_sel = 5'd12; step("R10 exc over rfe");
    idle(); step("R10 stack after");
    rfe = 1; mt_en = 1; mt_sel = 5'd12; mt_data = 32'h0000_003F; step("R10 rfe over mt");
    idle(); step("R10 rfe result");

    // random collisions across all functions
    for (int i = 0; i < 3000; i++) begin
      exc_req = ($urandom_range(0, 7) == 0);
      rfe = ($urandom_range(0, 5) == 0);
      mt_en = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 4))
        0: mt_sel = 5'd8; 1: mt_sel = 5'd12; 2: mt_sel = 5'd13; 3: mt_sel = 5'd14; default: mt_sel = 5'd1;
      endcase
      mt_data = $urandom;
      exc_code = 5'($urandom_range(0, 12));
      exc_pc = $urandom;
      exc_badaddr = $urandom;
      hw_irq = 6'($urandom);
      case ($urandom_range(0, 4))
        0: mf_sel = 5'd8; 1: mf_sel = 5'd12; 2: mf_sel = 5'd13; 3: mf_sel = 5'd14; default: mf_sel = 5'd20;
      endcase
      step("R10 random");
    end
    idle();
    rst_n = 0; step("reset"); rst_n = 1;
    read_all("R1 second reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule